// File: doc/BRIEF.md
# Paged Data Address Generator

This block forms the byte addresses that a CPU's load and store paths present to a 16-bit data space. It holds two identical generators, one for the read side and one for the write side. Both are evaluated in the same cycle and neither affects the other. Each generator takes a 16-bit pointer value from the register file, an addressing-mode code, a byte/word flag and a literal address field. From these it produces a 16-bit effective byte address. For the pointer-modifying modes it also produces the updated pointer value, with a strobe for register writeback.

The step applied to a pointer depends on the operand size. A byte access moves the pointer by one and a word access moves it by two. A word access to an odd address raises a misalignment flag, which the trap logic outside this block can use. Each side also has its own page register. The page value is placed above the 16-bit effective address to form a 24-bit extended address, so the two sides can reach a 16 MB space through different windows. The page registers load through a strobe and clear to page 0 at reset.

Address, pointer and flag outputs are combinational from the current inputs and the current page value. Only the page registers hold state.

Top module: `data_agu`

## Requirements
- R1: With mode code 0 (register indirect), the effective address equals the pointer input, the updated pointer equals the pointer input, and the writeback strobe is low.
- R2: With mode code 1 (post-increment) or 2 (post-decrement), the effective address equals the pointer input. The updated pointer is the pointer plus or minus the step, and the writeback strobe is high. The step is 1 when the byte flag is 1 and 2 when it is 0.
- R3: With mode code 3 (pre-increment) or 4 (pre-decrement), both the effective address and the updated pointer equal the pointer plus or minus the step, and the writeback strobe is high.
- R4: With mode code 5 (near direct), the effective address is the low 13 bits of the literal field zero-extended to 16 bits, so it always lies in 0x0000–0x1FFF. The writeback strobe is low.
- R5: With mode code 6 (full direct), the effective address equals the whole 16-bit literal field and the writeback strobe is low.
- R6: Each side's extended address is that side's 8-bit page value in bits 23:16 and its effective address in bits 15:0.
- R7: Both page registers read 0 after reset. A page register takes its data input at the clock edge where its load strobe is high, and holds its value at every other edge. Loading one side's page leaves the other side's page unchanged.
- R8: The misalignment flag is high exactly when the byte flag is 0 and bit 0 of the effective address is 1.
- R9: The read and write generators produce their outputs in the same cycle, each from its own inputs only.
- R10: Pointer arithmetic wraps modulo 2^16. For example, a word pre-decrement of 0x0000 gives 0xFFFE, and a byte post-increment of 0xFFFF gives an updated pointer of 0x0000.
- R11: Mode code 7 is reserved and behaves exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_base | input | 16 | Read-side pointer value |
| rd_mode | input | 3 | Read-side addressing-mode code |
| rd_byte | input | 1 | Read-side byte operation (1) or word operation (0) |
| rd_lit | input | 16 | Read-side literal address field |
| rd_page_ld | input | 1 | Read page register load strobe |
| rd_page_d | input | 8 | Read page register load value |
| wr_base | input | 16 | Write-side pointer value |
| wr_mode | input | 3 | Write-side addressing-mode code |
| wr_byte | input | 1 | Write-side byte operation (1) or word operation (0) |
| wr_lit | input | 16 | Write-side literal address field |
| wr_page_ld | input | 1 | Write page register load strobe |
| wr_page_d | input | 8 | Write page register load value |
| rd_ea | output | 16 | Read-side effective byte address |
| rd_xaddr | output | 24 | Read-side extended address |
| rd_ptr_new | output | 16 | Read-side updated pointer |
| rd_ptr_we | output | 1 | Read-side pointer writeback strobe |
| rd_misalign | output | 1 | Read-side word misalignment flag |
| wr_ea | output | 16 | Write-side effective byte address |
| wr_xaddr | output | 24 | Write-side extended address |
| wr_ptr_new | output | 16 | Write-side updated pointer |
| wr_ptr_we | output | 1 | Write-side pointer writeback strobe |
| wr_misalign | output | 1 | Write-side word misalignment flag |

## Verification
The assertions assume that every input is a known value at each sampled clock edge, and that neither page load strobe is high while reset is asserted. The page-load property relies on this, because a strobe seen during reset would not load. The stimulus changes inputs only on falling edges and holds both strobes low until reset is released. It also uses mode code 7 only in the scenario that checks it against register indirect.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_IND     = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_PREDEC  = 3'd4,
        AM_NEAR    = 3'd5,
        AM_FULL    = 3'd6,
        AM_RSVD    = 3'd7
    } addr_mode_e;

    typedef struct packed {
        logic       pre;
        logic       post;
        logic       down;
        logic       near;
        logic       full;
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(addr_mode_e m);
        mode_ctl_t c;
        c = '0;
        case (m)
            AM_POSTINC: c.post = 1'b1;
            AM_POSTDEC: begin c.post = 1'b1; c.down = 1'b1; end
            AM_PREINC:  c.pre  = 1'b1;
            AM_PREDEC:  begin c.pre  = 1'b1; c.down = 1'b1; end
            AM_NEAR:    c.near = 1'b1;
            AM_FULL:    c.full = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [1:0] step_size(logic is_byte);
        return is_byte ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/agu_page_reg.sv
module agu_page_reg #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end
endmodule

// File: rtl/agu_lane.sv
module agu_lane
    import agu_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NEAR_W = 13
) (
    input  logic [AW-1:0] base,
    input  addr_mode_e    mode,
    input  logic          is_byte,
    input  logic [AW-1:0] lit,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] ptr_new,
    output logic          ptr_we,
    output logic          misalign
);
    localparam int PADW = AW - NEAR_W;

    mode_ctl_t     ctl;
    logic [AW-1:0] step;
    logic [AW-1:0] moved;

    always_comb begin
        ctl   = decode_mode(mode);
        step  = {{(AW-2){1'b0}}, step_size(is_byte)};
        moved = ctl.down ? (base - step) : (base + step);

        if (ctl.near)
            ea = {{PADW{1'b0}}, lit[NEAR_W-1:0]};
        else if (ctl.full)
            ea = lit;
        else if (ctl.pre)
            ea = moved;
        else
            ea = base;

        ptr_we   = ctl.pre | ctl.post;
        ptr_new  = ptr_we ? moved : base;
        misalign = ~is_byte & ea[0];
    end
endmodule

// File: rtl/data_agu.sv
module data_agu
    import agu_pkg::*;
#(
    parameter int AW     = 16,
    parameter int PW     = 8,
    parameter int NEAR_W = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  rd_base,
    input  logic [2:0]     rd_mode,
    input  logic           rd_byte,
    input  logic [AW-1:0]  rd_lit,
    input  logic           rd_page_ld,
    input  logic [PW-1:0]  rd_page_d,
    input  logic [AW-1:0]  wr_base,
    input  logic [2:0]     wr_mode,
    input  logic           wr_byte,
    input  logic [AW-1:0]  wr_lit,
    input  logic           wr_page_ld,
    input  logic [PW-1:0]  wr_page_d,
    output logic [AW-1:0]  rd_ea,
    output logic [AW+PW-1:0] rd_xaddr,
    output logic [AW-1:0]  rd_ptr_new,
    output logic           rd_ptr_we,
    output logic           rd_misalign,
    output logic [AW-1:0]  wr_ea,
    output logic [AW+PW-1:0] wr_xaddr,
    output logic [AW-1:0]  wr_ptr_new,
    output logic           wr_ptr_we,
    output logic           wr_misalign
);
    localparam int NSIDE = 2;
    localparam int XW    = AW + PW;

    logic [AW-1:0] s_base  [NSIDE];
    addr_mode_e    s_mode  [NSIDE];
    logic          s_byte  [NSIDE];
    logic [AW-1:0] s_lit   [NSIDE];
    logic          s_ld    [NSIDE];
    logic [PW-1:0] s_pd    [NSIDE];
    logic [PW-1:0] s_page  [NSIDE];
    logic [AW-1:0] s_ea    [NSIDE];
    logic [AW-1:0] s_ptr   [NSIDE];
    logic          s_we    [NSIDE];
    logic          s_mis   [NSIDE];
    logic [XW-1:0] s_xa    [NSIDE];

    always_comb begin
        s_base[0] = rd_base;  s_base[1] = wr_base;
        s_mode[0] = addr_mode_e'(rd_mode);
        s_mode[1] = addr_mode_e'(wr_mode);
        s_byte[0] = rd_byte;  s_byte[1] = wr_byte;
        s_lit[0]  = rd_lit;   s_lit[1]  = wr_lit;
        s_ld[0]   = rd_page_ld; s_ld[1] = wr_page_ld;
        s_pd[0]   = rd_page_d;  s_pd[1] = wr_page_d;
    end

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        agu_page_reg #(.PW(PW)) u_page (
            .clk (clk),
            .rst (rst),
            .ld  (s_ld[i]),
            .d   (s_pd[i]),
            .q   (s_page[i])
        );

        agu_lane #(.AW(AW), .NEAR_W(NEAR_W)) u_lane (
            .base     (s_base[i]),
            .mode     (s_mode[i]),
            .is_byte  (s_byte[i]),
            .lit      (s_lit[i]),
            .ea       (s_ea[i]),
            .ptr_new  (s_ptr[i]),
            .ptr_we   (s_we[i]),
            .misalign (s_mis[i])
        );

        assign s_xa[i] = {s_page[i], s_ea[i]};
    end

    assign rd_ea       = s_ea[0];
    assign rd_xaddr    = s_xa[0];
    assign rd_ptr_new  = s_ptr[0];
    assign rd_ptr_we   = s_we[0];
    assign rd_misalign = s_mis[0];
    assign wr_ea       = s_ea[1];
    assign wr_xaddr    = s_xa[1];
    assign wr_ptr_new  = s_ptr[1];
    assign wr_ptr_we   = s_we[1];
    assign wr_misalign = s_mis[1];
endmodule

// File: rtl/data_agu_checker.sv
module data_agu_checker #(
    parameter int AW     = 16,
    parameter int PW     = 8,
    parameter int NEAR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     rd_base,
    input logic [2:0]        rd_mode,
    input logic              rd_byte,
    input logic              rd_page_ld,
    input logic [PW-1:0]     rd_page_d,
    input logic [AW-1:0]     rd_ea,
    input logic [AW+PW-1:0]  rd_xaddr,
    input logic [AW-1:0]     rd_ptr_new,
    input logic              rd_ptr_we,
    input logic              rd_misalign,
    input logic [AW-1:0]     wr_base,
    input logic [2:0]        wr_mode,
    input logic              wr_byte,
    input logic              wr_page_ld,
    input logic [PW-1:0]     wr_page_d,
    input logic [AW-1:0]     wr_ea,
    input logic [AW+PW-1:0]  wr_xaddr,
    input logic [AW-1:0]     wr_ptr_new,
    input logic              wr_ptr_we,
    input logic              wr_misalign
);
    localparam int XW = AW + PW;

    // R1 / R11: non-modifying indirect modes never request writeback
    p_ind_no_wb_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_mode == 3'd0 || rd_mode == 3'd7) |-> (!rd_ptr_we && rd_ea == rd_base));

    // R2: post-modify moves the pointer by exactly the size-dependent step
    p_post_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_mode == 3'd1) |-> (rd_ptr_we && rd_ea == rd_base &&
            (rd_ptr_new - rd_base) == (rd_byte ? AW'(1) : AW'(2))));

    // R3: pre-modify addresses memory with the updated pointer
    p_pre_same_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_mode == 3'd4) |-> (wr_ptr_we && wr_ea == wr_ptr_new &&
            (wr_base - wr_ptr_new) == (wr_byte ? AW'(1) : AW'(2))));

    // R4: near direct stays in the low region
    p_near_range_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_mode == 3'd5) |-> (rd_ea[AW-1:NEAR_W] == '0 && !rd_ptr_we));

    // R8: misalignment only for word accesses at odd addresses
    p_misalign_r8: assert property (@(posedge clk) disable iff (rst)
        rd_misalign |-> (!rd_byte && rd_ea[0]));

    // R6: low half of the extended address is the effective address
    p_xaddr_low_r6: assert property (@(posedge clk) disable iff (rst)
        wr_xaddr[AW-1:0] == wr_ea);

    // R7: page loads take effect at the next edge
    p_page_load_r7: assert property (@(posedge clk) disable iff (rst)
        rd_page_ld |=> (rd_xaddr[XW-1:AW] == $past(rd_page_d)));

    // R7: page holds without a load
    p_page_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_page_ld |=> $stable(wr_xaddr[XW-1:AW]));

    // R7: reset clears the page
    p_page_reset_r7: assert property (@(posedge clk)
        rst |=> (rd_xaddr[XW-1:AW] == '0 && wr_xaddr[XW-1:AW] == '0));
endmodule

bind data_agu data_agu_checker #(.AW(AW), .PW(PW), .NEAR_W(NEAR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_base     (rd_base),
    .rd_mode     (rd_mode),
    .rd_byte     (rd_byte),
    .rd_page_ld  (rd_page_ld),
    .rd_page_d   (rd_page_d),
    .rd_ea       (rd_ea),
    .rd_xaddr    (rd_xaddr),
    .rd_ptr_new  (rd_ptr_new),
    .rd_ptr_we   (rd_ptr_we),
    .rd_misalign (rd_misalign),
    .wr_base     (wr_base),
    .wr_mode     (wr_mode),
    .wr_byte     (wr_byte),
    .wr_page_ld  (wr_page_ld),
    .wr_page_d   (wr_page_d),
    .wr_ea       (wr_ea),
    .wr_xaddr    (wr_xaddr),
    .wr_ptr_new  (wr_ptr_new),
    .wr_ptr_we   (wr_ptr_we),
    .wr_misalign (wr_misalign)
);

// File: tb/data_agu_test.sv
`timescale 1ns/100ps
module data_agu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rd_base = '0, wr_base = '0, rd_lit = '0, wr_lit = '0;
    logic [2:0]  rd_mode = '0, wr_mode = '0;
    logic        rd_byte = 1'b0, wr_byte = 1'b0;
    logic        rd_page_ld = 1'b0, wr_page_ld = 1'b0;
    logic [7:0]  rd_page_d = '0, wr_page_d = '0;
    logic [15:0] rd_ea, rd_ptr_new, wr_ea, wr_ptr_new;
    logic [23:0] rd_xaddr, wr_xaddr;
    logic        rd_ptr_we, rd_misalign, wr_ptr_we, wr_misalign;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    data_agu uut (
        .clk(clk), .rst(rst),
        .rd_base(rd_base), .rd_mode(rd_mode), .rd_byte(rd_byte), .rd_lit(rd_lit),
        .rd_page_ld(rd_page_ld), .rd_page_d(rd_page_d),
        .wr_base(wr_base), .wr_mode(wr_mode), .wr_byte(wr_byte), .wr_lit(wr_lit),
        .wr_page_ld(wr_page_ld), .wr_page_d(wr_page_d),
        .rd_ea(rd_ea), .rd_xaddr(rd_xaddr), .rd_ptr_new(rd_ptr_new),
        .rd_ptr_we(rd_ptr_we), .rd_misalign(rd_misalign),
        .wr_ea(wr_ea), .wr_xaddr(wr_xaddr), .wr_ptr_new(wr_ptr_new),
        .wr_ptr_we(wr_ptr_we), .wr_misalign(wr_misalign)
    );

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_rd(logic [15:0] b, logic [2:0] m, logic by, logic [15:0] l);
        @(negedge clk);
        rd_base = b; rd_mode = m; rd_byte = by; rd_lit = l;
        #1;
    endtask

    task automatic drive_wr(logic [15:0] b, logic [2:0] m, logic by, logic [15:0] l);
        @(negedge clk);
        wr_base = b; wr_mode = m; wr_byte = by; wr_lit = l;
        #1;
    endtask

    task automatic t_reset();
        drive_rd(16'h1234, 3'd0, 1'b1, 16'h0);
        drive_wr(16'h0ABC, 3'd0, 1'b1, 16'h0);
        check("R7 reset rd page", {16'h0, rd_xaddr[23:16]}, 24'h0);
        check("R7 reset wr page", {16'h0, wr_xaddr[23:16]}, 24'h0);
    endtask

    task automatic t_indirect();
        drive_rd(16'h2468, 3'd0, 1'b0, 16'hFFFF);
        check("R1 ea", rd_ea, 16'h2468);
        check("R1 ptr", rd_ptr_new, 16'h2468);
        check("R1 we", rd_ptr_we, 1'b0);
    endtask

    task automatic t_post();
        drive_rd(16'h1000, 3'd1, 1'b1, 16'h0);
        check("R2 postinc byte ea", rd_ea, 16'h1000);
        check("R2 postinc byte ptr", rd_ptr_new, 16'h1001);
        check("R2 postinc we", rd_ptr_we, 1'b1);
        drive_rd(16'h1000, 3'd1, 1'b0, 16'h0);
        check("R2 postinc word ptr", rd_ptr_new, 16'h1002);
        drive_rd(16'h1000, 3'd2, 1'b0, 16'h0);
        check("R2 postdec word ea", rd_ea, 16'h1000);
        check("R2 postdec word ptr", rd_ptr_new, 16'h0FFE);
        drive_rd(16'h1000, 3'd2, 1'b1, 16'h0);
        check("R2 postdec byte ptr", rd_ptr_new, 16'h0FFF);
    endtask

    task automatic t_pre();
        drive_wr(16'h3000, 3'd3, 1'b0, 16'h0);
        check("R3 preinc word ea", wr_ea, 16'h3002);
        check("R3 preinc word ptr", wr_ptr_new, 16'h3002);
        check("R3 preinc we", wr_ptr_we, 1'b1);
        drive_wr(16'h3000, 3'd4, 1'b1, 16'h0);
        check("R3 predec byte ea", wr_ea, 16'h2FFF);
        check("R3 predec byte ptr", wr_ptr_new, 16'h2FFF);
    endtask

    task automatic t_direct();
        drive_rd(16'h5555, 3'd5, 1'b0, 16'hFABC);
        check("R4 near ea", rd_ea, 16'h1ABC);
        check("R4 near we", rd_ptr_we, 1'b0);
        check("R4 near ptr", rd_ptr_new, 16'h5555);
        drive_rd(16'h5555, 3'd6, 1'b1, 16'hFABC);
        check("R5 full ea", rd_ea, 16'hFABC);
        check("R5 full we", rd_ptr_we, 1'b0);
    endtask

    task automatic t_pages();
        @(negedge clk);
        rd_page_ld = 1'b1; rd_page_d = 8'h3C;
        #1;
        check("R7 no early load", {16'h0, rd_xaddr[23:16]}, 24'h0);
        @(negedge clk);
        rd_page_ld = 1'b0; rd_page_d = 8'hFF;
        drive_rd(16'h0042, 3'd0, 1'b0, 16'h0);
        drive_wr(16'h0044, 3'd0, 1'b0, 16'h0);
        check("R6 rd xaddr", rd_xaddr, 24'h3C0042);
        check("R7 wr page untouched", wr_xaddr, 24'h000044);
        @(negedge clk);
        wr_page_ld = 1'b1; wr_page_d = 8'hA5;
        @(negedge clk);
        wr_page_ld = 1'b0; wr_page_d = 8'h00;
        repeat (2) @(negedge clk);
        #1;
        check("R6 wr xaddr", wr_xaddr, 24'hA50044);
        check("R7 rd page held", rd_xaddr, 24'h3C0042);
    endtask

    task automatic t_misalign();
        drive_rd(16'h0101, 3'd0, 1'b0, 16'h0);
        check("R8 word odd", rd_misalign, 1'b1);
        drive_rd(16'h0101, 3'd0, 1'b1, 16'h0);
        check("R8 byte odd", rd_misalign, 1'b0);
        drive_rd(16'h0100, 3'd3, 1'b1, 16'h0);
        check("R8 byte preinc odd", rd_misalign, 1'b0);
        drive_rd(16'h0100, 3'd0, 1'b0, 16'h0);
        check("R8 word even", rd_misalign, 1'b0);
        drive_rd(16'h0000, 3'd6, 1'b0, 16'h0203);
        check("R8 word direct odd", rd_misalign, 1'b1);
    endtask

    task automatic t_wrap();
        drive_wr(16'h0000, 3'd4, 1'b0, 16'h0);
        check("R10 predec wrap", wr_ea, 16'hFFFE);
        drive_rd(16'hFFFF, 3'd1, 1'b1, 16'h0);
        check("R10 postinc wrap ptr", rd_ptr_new, 16'h0000);
        check("R10 postinc wrap ea", rd_ea, 16'hFFFF);
    endtask

    task automatic t_reserved();
        drive_rd(16'h7777, 3'd7, 1'b0, 16'h1234);
        check("R11 rsvd ea", rd_ea, 16'h7777);
        check("R11 rsvd we", rd_ptr_we, 1'b0);
        check("R11 rsvd ptr", rd_ptr_new, 16'h7777);
    endtask

    task automatic t_parallel();
        @(negedge clk);
        rd_base = 16'h0800; rd_mode = 3'd1; rd_byte = 1'b0; rd_lit = 16'h0;
        wr_base = 16'h0900; wr_mode = 3'd4; wr_byte = 1'b1; wr_lit = 16'h0;
        #1;
        check("R9 rd ptr", rd_ptr_new, 16'h0802);
        check("R9 wr ea", wr_ea, 16'h08FF);
        check("R9 rd ea", rd_ea, 16'h0800);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_indirect();
        t_post();
        t_pre();
        t_direct();
        t_pages();
        t_misalign();
        t_wrap();
        t_reserved();
        t_parallel();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule